// File: doc/BRIEF.md
# Software-Triggered Interrupt Enable and Pend Unit

This block holds the enable and pending state for a bank of external interrupt lines and offers it to the core. It has two memory-mapped registers on a simple single-cycle register bus. The enable register can only be set: each 1 written turns its line on, and a read returns the current enables, so software can update it by read-modify-write. A write to the trigger register names one line by number and marks it pending, just as a pulse on that line's hardware request input does.

Each cycle the unit picks the lowest-numbered line that is both pending and enabled. It presents that line to the core as an exception number, which is the line index plus a fixed base of 16. The pending bit stays set until the core acknowledges that exception number. Every register write carries the requester's privilege level. An unprivileged write to either register leaves the register unchanged and raises a one-cycle fault pulse instead.

Top module: `irq_gate_unit`

## Requirements
- R1: When `rst` is held high across a clock edge, all enables and pending bits are cleared, and after that edge `exc_valid`, `exc_num`, `bus_fault` and `bus_rdata` are all zero.
- R2: A privileged write to offset 0x100 enables line n for every bit n of `bus_wdata` that is 1. Bits written as 0 leave their enable unchanged, and an enable never clears except by reset.
- R3: A read of offset 0x100 returns the enables as they stood before that cycle's edge, on `bus_rdata` in the following cycle. In any cycle that follows no such read, `bus_rdata` is zero.
- R4: A privileged write to offset 0xF00 takes `bus_wdata[8:0]` as a line ID and pends that line. Higher data bits are ignored, and IDs from 32 to 511 change nothing.
- R5: `hw_req[n]` high during a clock edge pends line n.
- R6: A pending bit stays set, whether or not its line is enabled, until a clock edge where `exc_ack` is high with `exc_ack_num` equal to n+16. A new request for the same line at that same edge keeps the bit set.
- R7: One edge after the enable and pending state changes, `exc_valid` is 1 and `exc_num` equals n+16, where n is the lowest line that is both pending and enabled.
- R8: An unprivileged write (`bus_priv` = 0) to offset 0x100 or 0xF00 changes no state. It drives `bus_fault` high in the following cycle, for one cycle per such write.
- R9: A write to any other offset changes no state and raises no fault.
- R10: When no line is both pending and enabled, `exc_valid` and `exc_num` are 0 one edge later.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_priv | input | 1 | 1 = requester is privileged |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_fault | output | 1 | One-cycle pulse after a rejected unprivileged write |
| hw_req | input | 32 | Hardware request, one bit per line |
| exc_valid | output | 1 | An exception is being presented |
| exc_num | output | 6 | Presented exception number (line + 16), 0 when idle |
| exc_ack | input | 1 | Core acknowledges `exc_ack_num` |
| exc_ack_num | input | 6 | Exception number being acknowledged |

## Verification
An access changes the enable and pending state at the edge where it is sampled. `bus_fault` and `bus_rdata` therefore answer one edge after the access, while the exception outputs trail the state by one more edge: a trigger write or a request shows up two edges after it is applied. The bench keeps a reference copy of the enable and pending state. Before each edge it works out what the outputs must show after that edge, from the state as it stood and the inputs being applied, then samples 1 ns after the edge. The directed checks wait the same counted number of edges before they compare.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  // Which register a bus access selects
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ENA  = 2'd1,
    TGT_TRG  = 2'd2
  } tgt_e;

  // Qualified write command produced by the bus decoder
  typedef struct packed {
    logic ena_we;
    logic trg_we;
    logic deny;
  } wr_cmd_t;

endpackage

// File: rtl/irq_gate_regif.sv
module irq_gate_regif
  import irq_gate_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 32,
  parameter int ID_W      = 9,
  parameter logic [ADDR_W-1:0] ENA_OFS = 'h100,
  parameter logic [ADDR_W-1:0] TRG_OFS = 'hF00
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_priv,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [NUM_LINES-1:0] ena_q,
  output logic [NUM_LINES-1:0] ena_set,
  output logic [NUM_LINES-1:0] trg_set,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_fault
);

  tgt_e            tgt;
  wr_cmd_t         cmd;
  logic [ID_W-1:0] trg_id;
  logic            unused_wdata;

  always_comb begin
    if (bus_addr == ENA_OFS)      tgt = TGT_ENA;
    else if (bus_addr == TRG_OFS) tgt = TGT_TRG;
    else                          tgt = TGT_NONE;
  end

  always_comb begin
    cmd.ena_we = bus_wr && bus_priv && (tgt == TGT_ENA);
    cmd.trg_we = bus_wr && bus_priv && (tgt == TGT_TRG);
    cmd.deny   = bus_wr && !bus_priv && (tgt != TGT_NONE);
  end

  assign trg_id       = bus_wdata[ID_W-1:0];
  assign ena_set      = cmd.ena_we ? bus_wdata[NUM_LINES-1:0] : '0;
  assign unused_wdata = ^bus_wdata;

  // One comparator per implemented line; IDs beyond the last line match none
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_trg
    assign trg_set[i] = cmd.trg_we && (trg_id == ID_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_fault <= 1'b0;
    end else begin
      bus_rdata <= (bus_rd && tgt == TGT_ENA) ? DATA_W'(ena_q) : '0;
      bus_fault <= cmd.deny;
    end
  end

  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    bus_fault |-> ($past(bus_wr) && !$past(bus_priv))); // R8

endmodule

// File: rtl/irq_gate_lines.sv
module irq_gate_lines #(
  parameter int NUM_LINES = 32,
  parameter int EXC_BASE  = 16,
  parameter int EXC_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] ena_set,
  input  logic [NUM_LINES-1:0] pend_set,
  input  logic                 exc_ack,
  input  logic [EXC_W-1:0]     exc_ack_num,
  output logic [NUM_LINES-1:0] ena_q,
  output logic [NUM_LINES-1:0] pend_q
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic ena_r;
    logic pend_r;
    logic ack_hit;

    assign ack_hit = exc_ack && (exc_ack_num == EXC_W'(EXC_BASE + i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ena_r  <= 1'b0;
        pend_r <= 1'b0;
      end else begin
        if (ena_set[i]) ena_r <= 1'b1;
        // a fresh request wins over an acknowledge in the same cycle
        if (pend_set[i])   pend_r <= 1'b1;
        else if (ack_hit)  pend_r <= 1'b0;
      end
    end

    assign ena_q[i]  = ena_r;
    assign pend_q[i] = pend_r;
  end

  AST_ENA_NEVER_FALLS: assert property (@(posedge clk) disable iff (rst)
    ((ena_q & $past(ena_q)) == $past(ena_q))); // R2

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exc_ack |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R6

endmodule

// File: rtl/irq_gate_pick.sv
module irq_gate_pick #(
  parameter int NUM_LINES = 32,
  parameter int EXC_BASE  = 16,
  parameter int EXC_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_vec,
  output logic                 exc_valid,
  output logic [EXC_W-1:0]     exc_num
);

  logic             hit_d;
  logic [EXC_W-1:0] num_d;

  // Scan from the top down so the lowest requesting line is the last to assign
  always_comb begin
    hit_d = |req_vec;
    num_d = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req_vec[i]) num_d = EXC_W'(EXC_BASE + i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_num   <= '0;
    end else begin
      exc_valid <= hit_d;
      exc_num   <= num_d;
    end
  end

  AST_NUM_RANGE: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_num >= EXC_W'(EXC_BASE) &&
                   exc_num <= EXC_W'(EXC_BASE + NUM_LINES - 1))); // R7

endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_LINES = 32,
  parameter int ID_W      = 9,
  parameter int EXC_BASE  = 16,
  parameter logic [ADDR_W-1:0] ENA_OFS = 'h100,
  parameter logic [ADDR_W-1:0] TRG_OFS = 'hF00,
  localparam int EXC_W = $clog2(EXC_BASE + NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_priv,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_fault,
  input  logic [NUM_LINES-1:0] hw_req,
  output logic                 exc_valid,
  output logic [EXC_W-1:0]     exc_num,
  input  logic                 exc_ack,
  input  logic [EXC_W-1:0]     exc_ack_num
);

  logic [NUM_LINES-1:0] ena_set;
  logic [NUM_LINES-1:0] trg_set;
  logic [NUM_LINES-1:0] pend_set;
  logic [NUM_LINES-1:0] ena_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] req_vec;

  irq_gate_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .ID_W(ID_W),
    .ENA_OFS(ENA_OFS), .TRG_OFS(TRG_OFS)
  ) u_regif (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_priv(bus_priv),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ena_q(ena_q), .ena_set(ena_set), .trg_set(trg_set),
    .bus_rdata(bus_rdata), .bus_fault(bus_fault)
  );

  assign pend_set = hw_req | trg_set;

  irq_gate_lines #(
    .NUM_LINES(NUM_LINES), .EXC_BASE(EXC_BASE), .EXC_W(EXC_W)
  ) u_lines (
    .clk(clk), .rst(rst),
    .ena_set(ena_set), .pend_set(pend_set),
    .exc_ack(exc_ack), .exc_ack_num(exc_ack_num),
    .ena_q(ena_q), .pend_q(pend_q)
  );

  assign req_vec = ena_q & pend_q;

  irq_gate_pick #(
    .NUM_LINES(NUM_LINES), .EXC_BASE(EXC_BASE), .EXC_W(EXC_W)
  ) u_pick (
    .clk(clk), .rst(rst), .req_vec(req_vec),
    .exc_valid(exc_valid), .exc_num(exc_num)
  );

  AST_UNPRIV_KEEPS_ENA: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_priv) |=> $stable(ena_q)); // R8

  AST_VALID_NEEDS_ENA: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (|$past(ena_q))); // R7

  AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !(|$past(ena_q & pend_q)) |-> (!exc_valid && exc_num == '0)); // R10

endmodule

// File: tb/sim_irq_gate_unit.sv
module sim_irq_gate_unit;

  localparam logic [11:0] A_ENA = 12'h100;
  localparam logic [11:0] A_TRG = 12'hF00;

  logic        clk = 1'b0;
  logic        rst, wr, rd, priv, ack;
  logic [11:0] addr;
  logic [31:0] wdata, hw;
  logic [5:0]  ack_num;
  logic [31:0] bus_rdata;
  logic        bus_fault, exc_valid;
  logic [5:0]  exc_num;

  logic [31:0] m_ena, m_pend;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  irq_gate_unit u0 (
    .clk(clk), .rst(rst),
    .bus_wr(wr), .bus_rd(rd), .bus_priv(priv),
    .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(bus_rdata), .bus_fault(bus_fault),
    .hw_req(hw),
    .exc_valid(exc_valid), .exc_num(exc_num),
    .exc_ack(ack), .exc_ack_num(ack_num)
  );

  task automatic chk(input bit ok, input string req, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s (%s): actual %0h expected %0h", req, tag, act, exp);
    end
  endtask

  function automatic logic [6:0] pick_model(input logic [31:0] req);
    logic [6:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) if (req[i]) r = {1'b1, 6'(i + 16)};
    return r;
  endfunction

  task automatic idle_inputs();
    wr = 0; rd = 0; priv = 1; addr = '0; wdata = '0; hw = '0; ack = 0; ack_num = '0;
  endtask

  // One clock cycle: predict, step, update the model, compare every output
  task automatic cyc(input string tag);
    logic [6:0]  e_exc;
    logic        e_flt;
    logic [31:0] e_rd, setm, clrm;
    e_exc = rst ? 7'd0 : pick_model(m_ena & m_pend);
    e_flt = !rst && wr && !priv && (addr == A_ENA || addr == A_TRG);
    e_rd  = (!rst && rd && addr == A_ENA) ? m_ena : 32'd0;
    setm  = hw;
    if (wr && priv && addr == A_TRG && wdata[8:0] < 9'd32) setm[wdata[4:0]] = 1'b1;
    clrm  = '0;
    for (int i = 0; i < 32; i++) if (ack && ack_num == 6'(i + 16)) clrm[i] = 1'b1;
    @(posedge clk);
    #1;
    if (rst) begin
      m_ena = '0; m_pend = '0;
    end else begin
      if (wr && priv && addr == A_ENA) m_ena = m_ena | wdata;
      m_pend = (m_pend & ~clrm) | setm;
    end
    chk({exc_valid, exc_num} === e_exc, "R7", tag, {25'd0, exc_valid, exc_num}, {25'd0, e_exc});
    chk(bus_fault === e_flt, "R8", tag, {31'd0, bus_fault}, {31'd0, e_flt});
    chk(bus_rdata === e_rd, "R3", tag, bus_rdata, e_rd);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, input logic p, input string tag);
    idle_inputs(); wr = 1; addr = a; wdata = d; priv = p;
    cyc(tag);
    idle_inputs();
  endtask

  task automatic rd_reg(input logic [11:0] a, input string tag);
    idle_inputs(); rd = 1; addr = a;
    cyc(tag);
    idle_inputs();
  endtask

  task automatic ack_exc(input logic [5:0] n, input logic [31:0] req, input string tag);
    idle_inputs(); ack = 1; ack_num = n; hw = req;
    cyc(tag);
    idle_inputs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle_inputs();
    m_ena = '0; m_pend = '0;
    rst = 1;
    repeat (3) cyc("R1 reset");
    rst = 0;
    chk(!exc_valid && exc_num == 0 && !bus_fault && bus_rdata == 0, "R1", "after reset",
        {exc_valid, bus_fault, exc_num, bus_rdata[23:0]}, 32'd0);

    // R2 / R3: set-only enables, read back
    wr_reg(A_ENA, 32'h5, 1, "R2 set");
    wr_reg(A_ENA, 32'h0, 1, "R2 zero write");
    rd_reg(A_ENA, "R3 read");
    chk(bus_rdata == 32'h5, "R2", "zeros keep enables", bus_rdata, 32'h5);
    // R8: unprivileged enable write rejected
    wr_reg(A_ENA, 32'hF0, 0, "R8 unpriv ena");
    chk(bus_fault == 1'b1, "R8", "fault pulse", {31'd0, bus_fault}, 32'd1);
    rd_reg(A_ENA, "R8 readback");
    chk(bus_rdata == 32'h5 && !bus_fault, "R8", "enables unchanged", bus_rdata, 32'h5);

    // R4 / R6: trigger ID 3 via data 0x203, line disabled first
    wr_reg(A_TRG, 32'h203, 1, "R4 trigger");
    cyc("R6 idle");
    chk(!exc_valid, "R6", "pending but disabled", {31'd0, exc_valid}, 32'd0);
    wr_reg(A_ENA, 32'h8, 1, "R6 enable late");
    cyc("R4 present");
    chk(exc_valid && exc_num == 6'd19, "R4", "line 3 -> 19", {26'd0, exc_num}, 32'd19);
    ack_exc(6'd19, 32'd0, "R6 ack");
    cyc("R6 after ack");
    chk(!exc_valid && exc_num == 0, "R6", "ack clears", {25'd0, exc_valid, exc_num}, 32'd0);

    // R4: high IDs ignored; R9: unmapped offsets ignored
    wr_reg(A_ENA, 32'hFFFF_FFFF, 1, "R2 all");
    wr_reg(A_TRG, 32'd40, 1, "R4 id 40");
    wr_reg(A_TRG, 32'h1FF, 1, "R4 id 511");
    cyc("R4 idle");
    chk(!exc_valid, "R4", "large IDs ignored", {31'd0, exc_valid}, 32'd0);
    wr_reg(A_TRG, 32'd5, 0, "R8 unpriv trg");
    chk(bus_fault, "R8", "trigger fault", {31'd0, bus_fault}, 32'd1);
    cyc("R8 idle");
    chk(!exc_valid && !bus_fault, "R8", "no pend from unpriv", {30'd0, exc_valid, bus_fault}, 32'd0);
    wr_reg(12'hF04, 32'd2, 1, "R9 near trg");
    chk(!bus_fault, "R9", "no fault", {31'd0, bus_fault}, 32'd0);
    wr_reg(12'h104, 32'd0, 0, "R9 unpriv unmapped");
    chk(!bus_fault, "R9", "no fault unpriv", {31'd0, bus_fault}, 32'd0);
    cyc("R9 idle");
    chk(!exc_valid, "R9", "no pend", {31'd0, exc_valid}, 32'd0);

    // R5 / R7: two hardware requests, lowest first
    idle_inputs(); hw = 32'h0000_0210; cyc("R5 hw"); idle_inputs();
    cyc("R7 idle");
    chk(exc_valid && exc_num == 6'd20, "R5", "line 4 first", {26'd0, exc_num}, 32'd20);
    ack_exc(6'd20, 32'd0, "R7 ack 20");
    cyc("R7 next");
    chk(exc_valid && exc_num == 6'd25, "R7", "then line 9", {26'd0, exc_num}, 32'd25);
    ack_exc(6'd25, 32'd0, "R7 ack 25");
    cyc("R10 a"); cyc("R10 b");
    chk(!exc_valid && exc_num == 0, "R10", "idle when empty", {25'd0, exc_valid, exc_num}, 32'd0);

    // R6: request in the same cycle as the acknowledge keeps the line pending
    idle_inputs(); hw = 32'h4; cyc("R6 hw2"); idle_inputs();
    cyc("R6 wait");
    ack_exc(6'd18, 32'h4, "R6 ack+req");
    cyc("R6 c"); cyc("R6 d");
    chk(exc_valid && exc_num == 6'd18, "R6", "set wins", {26'd0, exc_num}, 32'd18);
    ack_exc(6'd18, 32'd0, "R6 final ack");

    // Random phases separated by reset
    for (int ph = 0; ph < 3; ph++) begin
      idle_inputs(); rst = 1; cyc("R1 rephase"); cyc("R1 rephase"); rst = 0;
      for (int k = 0; k < 3000; k++) begin
        idle_inputs();
        case ($urandom % 4)
          0: addr = A_ENA;
          1: addr = A_TRG;
          2: addr = 12'($urandom);
          default: addr = A_TRG;
        endcase
        wr   = ($urandom % 3) == 0;
        rd   = ($urandom % 3) == 0;
        priv = ($urandom % 4) != 0;
        wdata = (addr == A_ENA) ? ($urandom & $urandom & $urandom & $urandom)
                                : (($urandom & 32'hFFFF_FE00) | ($urandom % 48));
        if (($urandom % 4) == 0) hw = $urandom & $urandom & $urandom & $urandom;
        if (exc_valid && ($urandom % 2) == 0) begin ack = 1; ack_num = exc_num; end
        else if (($urandom % 8) == 0) begin ack = 1; ack_num = 6'($urandom); end
        cyc("random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule